// File: doc/BRIEF.md
# Chained Scatter-Gather DMA Controller

A single-channel DMA engine that moves words between a host memory space and a local bus. Software programs a mode word, a host address, a local address, a byte count and a pointer through a small register port, then writes both enable and go bits into the command/status register. In direct mode the engine runs one transfer from the programmed registers. In chained mode it fetches four-word descriptors from host memory and walks the chain until it finishes the descriptor that is flagged as last. When the whole job is finished, a done bit in the status register is set.

Each beat is a read from the source bus followed by a write to the destination bus. One host word is used per beat, and only the low local-width bits of that word are significant. Both buses use a request/ready handshake. Waiting on local ready can be switched off, in which case every local access completes in the cycle it is issued.

The engine is a single state machine:
- States: IDLE, FETCH, CHECK, READ, WRITE, SEGEND.
- Transitions:
  - IDLE→FETCH on an accepted go with chaining on.
  - IDLE→CHECK on an accepted go in direct mode.
  - FETCH→CHECK after the fourth descriptor word.
  - CHECK→SEGEND when the beat count is zero; CHECK→READ otherwise.
  - READ→WRITE when the source access completes.
  - WRITE→READ when beats remain; WRITE→SEGEND on the final beat.
  - SEGEND→FETCH when the segment is not the last one; SEGEND→IDLE (which sets done) when it is.

Top module: `dmac_sg_top`

## Requirements
- R1: Register index 0 holds the mode, 1 the host address, 2 the local address, 3 the byte count and 4 the pointer. Each reads back what was written. Index 5 is command/status and reads bit 4 as done with all other bits zero. After reset every register and the done bit are zero, and no bus request is raised.
- R2: A write to index 5 with bit 0 and bit 1 both set starts a job when the engine is idle. A write with only one of the two bits set starts nothing.
- R3: With mode bit 9 clear (direct mode), one transfer runs from registers 1 to 3. Pointer bit 3 picks the direction: 1 moves local to host, 0 moves host to local. The host address advances by 4 bytes per beat.
- R4: Mode bits [1:0] set the local width: 00 is 8-bit, 01 is 16-bit, 11 or 10 is 32-bit. The number of beats is the byte count divided by the width in bytes, with any remainder dropped. Local writes carry only the low width bits of the host word. Local reads are zero-extended above the width.
- R5: The local address advances by the width in bytes on each beat. When mode bit 11 is set it stays constant.
- R6: With mode bit 9 set, descriptors are read from the pointer with its low 4 bits cleared. A descriptor's words are, in order: host address, local address, byte count, next pointer. In the next pointer, bit 3 is the direction and bit 1 marks the last descriptor. The next descriptor address is the next pointer with its low 4 bits cleared.
- R7: A descriptor whose beat count is zero moves no data. The engine then follows its next pointer, or finishes if the descriptor is the last one.
- R8: Status bit 4 becomes 1 when the job has fully completed, and clears when a new go is accepted.
- R9: A go written while a job is running is ignored, and register writes made during a job do not affect it.
- R10: With mode bit 6 set, each local access waits for local ready. With it clear, each local access completes in the cycle it is issued.
- R11: A host request keeps its address, write flag and write data stable until host ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| h_req | output | 1 | Host access request |
| h_we | output | 1 | Host write flag |
| h_addr | output | ADDR_W | Host byte address |
| h_wdata | output | 32 | Host write data |
| h_rdata | input | 32 | Host read data |
| h_rdy | input | 1 | Host access complete |
| l_req | output | 1 | Local access request |
| l_we | output | 1 | Local write flag |
| l_addr | output | ADDR_W | Local address |
| l_wdata | output | 32 | Local write data |
| l_rdata | input | 32 | Local read data |
| l_rdy | input | 1 | Local access complete |

## Verification
The bench targets the following corner cases:
- Byte counts that are not a multiple of the width. A design that rounds up instead of truncating writes an extra beat.
- A held local address. A design that advances it anyway spreads data across the local memory.
- A zero-count descriptor inside a chain, and a zero-count descriptor at the end of a chain. A design that skips neither would copy a stray word.
- A go issued while the engine is stalled on local ready. A design that accepts it restarts at the new addresses.
- Local ready held low with waiting disabled. A design that waits anyway never finishes.

Host ready is also throttled, which catches a design that loses or re-reads data across stalls.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W     = 32;
    localparam int MODE_WAIT  = 6;
    localparam int MODE_CHAIN = 9;
    localparam int MODE_HOLD  = 11;
    localparam int PTR_LAST   = 1;
    localparam int PTR_DIR    = 3;
    localparam int CSR_EN     = 0;
    localparam int CSR_GO     = 1;
    localparam int CSR_DONE   = 4;
    localparam logic [2:0] RIX_MODE  = 3'd0;
    localparam logic [2:0] RIX_HADDR = 3'd1;
    localparam logic [2:0] RIX_LADDR = 3'd2;
    localparam logic [2:0] RIX_COUNT = 3'd3;
    localparam logic [2:0] RIX_PTR   = 3'd4;
    localparam logic [2:0] RIX_CSR   = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_SEGEND
    } dma_state_e;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              busy,
    input  logic              finish,
    output logic              go,
    output logic [1:0]        w_sel,
    output logic              wait_en,
    output logic              hold_en,
    output logic              chain_en,
    output logic [ADDR_W-1:0] haddr,
    output logic [ADDR_W-1:0] laddr,
    output logic [WORD_W-1:0] count,
    output logic [ADDR_W-5:0] ptr_base,
    output logic              ptr_dir
);
    logic [WORD_W-1:0] mode_q, haddr_q, laddr_q, count_q, ptr_q;
    logic              done_q;

    assign go = wr && (addr == RIX_CSR) && wdata[CSR_EN] && wdata[CSR_GO] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            haddr_q <= '0;
            laddr_q <= '0;
            count_q <= '0;
            ptr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            if (wr) begin
                unique case (addr)
                    RIX_MODE:  mode_q  <= wdata;
                    RIX_HADDR: haddr_q <= wdata;
                    RIX_LADDR: laddr_q <= wdata;
                    RIX_COUNT: count_q <= wdata;
                    RIX_PTR:   ptr_q   <= wdata;
                    default: ;
                endcase
            end
            if (go)
                done_q <= 1'b0;
            else if (finish)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (addr)
            RIX_MODE:  rdata = mode_q;
            RIX_HADDR: rdata = haddr_q;
            RIX_LADDR: rdata = laddr_q;
            RIX_COUNT: rdata = count_q;
            RIX_PTR:   rdata = ptr_q;
            RIX_CSR:   rdata = WORD_W'(done_q) << CSR_DONE;
            default:   rdata = '0;
        endcase
    end

    assign w_sel    = mode_q[1:0];
    assign wait_en  = mode_q[MODE_WAIT];
    assign hold_en  = mode_q[MODE_HOLD];
    assign chain_en = mode_q[MODE_CHAIN];
    assign haddr    = haddr_q[ADDR_W-1:0];
    assign laddr    = laddr_q[ADDR_W-1:0];
    assign count    = count_q;
    assign ptr_base = ptr_q[ADDR_W-1:4];
    assign ptr_dir  = ptr_q[PTR_DIR];

    // R8: an accepted go clears done on the next cycle
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !done_q);
    // R8: done is only ever visible while the engine sits idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        w_sel,
    input  logic              wait_en,
    input  logic              hold_en,
    input  logic              chain_en,
    input  logic [ADDR_W-1:0] reg_haddr,
    input  logic [ADDR_W-1:0] reg_laddr,
    input  logic [WORD_W-1:0] reg_count,
    input  logic [ADDR_W-5:0] reg_ptr_base,
    input  logic              reg_ptr_dir,
    output logic              busy,
    output logic              finish,
    output logic              h_req,
    output logic              h_we,
    output logic [ADDR_W-1:0] h_addr,
    output logic [WORD_W-1:0] h_wdata,
    input  logic [WORD_W-1:0] h_rdata,
    input  logic              h_rdy,
    output logic              l_req,
    output logic              l_we,
    output logic [ADDR_W-1:0] l_addr,
    output logic [WORD_W-1:0] l_wdata,
    input  logic [WORD_W-1:0] l_rdata,
    input  logic              l_rdy
);
    dma_state_e        state, st_nx;
    logic [ADDR_W-5:0] ptr, nxt;
    logic [1:0]        widx, wsel_r;
    logic [ADDR_W-1:0] cur_h, cur_l, wb;
    logic [WORD_W-1:0] cnt, beats, beats_calc, data_q, mask;
    logic              dir, last, chain_r, wait_r, hold_r;
    logic              hcmp, lcmp, src_cmp, dst_cmp;
    int unsigned       shamt;

    always_comb begin
        unique case (wsel_r)
            2'b00:   begin mask = WORD_W'(32'h0000_00FF); wb = ADDR_W'(1); shamt = 0; end
            2'b01:   begin mask = WORD_W'(32'h0000_FFFF); wb = ADDR_W'(2); shamt = 1; end
            default: begin mask = '1;                     wb = ADDR_W'(4); shamt = 2; end
        endcase
    end

    assign beats_calc = cnt >> shamt;
    assign hcmp    = h_req && h_rdy;
    assign lcmp    = l_req && (l_rdy || !wait_r);
    assign src_cmp = dir ? lcmp : hcmp;
    assign dst_cmp = dir ? hcmp : lcmp;
    assign busy    = (state != ST_IDLE);
    assign finish  = (state == ST_SEGEND) && last;

    always_comb begin
        st_nx = state;
        unique case (state)
            ST_IDLE:   if (go) st_nx = chain_en ? ST_FETCH : ST_CHECK;
            ST_FETCH:  if (hcmp && widx == 2'd3) st_nx = ST_CHECK;
            ST_CHECK:  st_nx = (beats_calc == '0) ? ST_SEGEND : ST_READ;
            ST_READ:   if (src_cmp) st_nx = ST_WRITE;
            ST_WRITE:  if (dst_cmp) st_nx = (beats == WORD_W'(1)) ? ST_SEGEND : ST_READ;
            ST_SEGEND: st_nx = last ? ST_IDLE : ST_FETCH;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr <= '0; nxt <= '0; widx <= '0; wsel_r <= '0;
            cur_h <= '0; cur_l <= '0; cnt <= '0; beats <= '0; data_q <= '0;
            dir <= 1'b0; last <= 1'b0; chain_r <= 1'b0; wait_r <= 1'b0; hold_r <= 1'b0;
        end else begin
            state <= st_nx;
            unique case (state)
                ST_IDLE: if (go) begin
                    chain_r <= chain_en;
                    wait_r  <= wait_en;
                    hold_r  <= hold_en;
                    wsel_r  <= w_sel;
                    widx    <= '0;
                    ptr     <= reg_ptr_base;
                    cur_h   <= reg_haddr;
                    cur_l   <= reg_laddr;
                    cnt     <= reg_count;
                    dir     <= reg_ptr_dir;
                    last    <= !chain_en;
                end
                ST_FETCH: if (hcmp) begin
                    widx <= widx + 2'd1;
                    unique case (widx)
                        2'd0: cur_h <= h_rdata[ADDR_W-1:0];
                        2'd1: cur_l <= h_rdata[ADDR_W-1:0];
                        2'd2: cnt   <= h_rdata;
                        default: begin
                            nxt  <= h_rdata[ADDR_W-1:4];
                            dir  <= h_rdata[PTR_DIR];
                            last <= h_rdata[PTR_LAST];
                        end
                    endcase
                end
                ST_CHECK: beats <= beats_calc;
                ST_READ: if (src_cmp) data_q <= dir ? (l_rdata & mask) : h_rdata;
                ST_WRITE: if (dst_cmp) begin
                    cur_h <= cur_h + ADDR_W'(4);
                    if (!hold_r) cur_l <= cur_l + wb;
                    beats <= beats - WORD_W'(1);
                end
                ST_SEGEND: if (!last) begin
                    ptr  <= nxt;
                    widx <= '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0;
        l_req = 1'b0; l_we = 1'b0; l_addr = '0; l_wdata = '0;
        unique case (state)
            ST_FETCH: begin
                h_req  = 1'b1;
                h_addr = {ptr, widx, 2'b00};
            end
            ST_READ: begin
                if (dir) begin l_req = 1'b1; l_addr = cur_l; end
                else     begin h_req = 1'b1; h_addr = cur_h; end
            end
            ST_WRITE: begin
                if (dir) begin
                    h_req = 1'b1; h_we = 1'b1; h_addr = cur_h; h_wdata = data_q;
                end else begin
                    l_req = 1'b1; l_we = 1'b1; l_addr = cur_l; l_wdata = data_q & mask;
                end
            end
            default: ;
        endcase
    end

    // R11: a stalled host request holds still until ready
    assert_host_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_rdy) |=> (h_req && $stable(h_addr) && $stable(h_we) && $stable(h_wdata)));
    // R10: with waiting on, a stalled local request holds still until ready
    assert_local_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_req && !l_rdy && wait_r) |=> (l_req && $stable(l_addr) && $stable(l_we)));
endmodule

// File: rtl/dmac_sg_top.sv
module dmac_sg_top
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              h_req,
    output logic              h_we,
    output logic [ADDR_W-1:0] h_addr,
    output logic [31:0]       h_wdata,
    input  logic [31:0]       h_rdata,
    input  logic              h_rdy,
    output logic              l_req,
    output logic              l_we,
    output logic [ADDR_W-1:0] l_addr,
    output logic [31:0]       l_wdata,
    input  logic [31:0]       l_rdata,
    input  logic              l_rdy
);
    logic              busy, finish, go, wait_en, hold_en, chain_en, ptr_dir;
    logic [1:0]        w_sel;
    logic [ADDR_W-1:0] haddr, laddr;
    logic [WORD_W-1:0] count;
    logic [ADDR_W-5:0] ptr_base;

    dmac_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .finish(finish), .go(go), .w_sel(w_sel),
        .wait_en(wait_en), .hold_en(hold_en), .chain_en(chain_en), .haddr(haddr),
        .laddr(laddr), .count(count), .ptr_base(ptr_base), .ptr_dir(ptr_dir)
    );

    dmac_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .w_sel(w_sel), .wait_en(wait_en),
        .hold_en(hold_en), .chain_en(chain_en), .reg_haddr(haddr), .reg_laddr(laddr),
        .reg_count(count), .reg_ptr_base(ptr_base), .reg_ptr_dir(ptr_dir),
        .busy(busy), .finish(finish),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rdy(h_rdy),
        .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rdy(l_rdy)
    );
endmodule

// File: tb/dmac_sg_top_test.sv
module dmac_sg_top_test;
    localparam int CLK_P = 10;
    localparam int NV    = 7;

    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] ha;
        logic [31:0] la;
        logic [31:0] cnt;
        logic        dir;
        logic        stall;
    } vec_t;

    // mode, host addr, local addr, byte count, direction, host stall
    localparam vec_t VT [NV] = '{
        '{32'h043, 32'h000, 32'h00, 32'd16, 1'b0, 1'b0},  // R3 32-bit host->local
        '{32'h041, 32'h040, 32'h40, 32'd10, 1'b0, 1'b1},  // R4 R5 16-bit
        '{32'h040, 32'h080, 32'h80, 32'd6,  1'b1, 1'b0},  // R4 8-bit local->host
        '{32'h843, 32'h0C0, 32'hC0, 32'd12, 1'b0, 1'b1},  // R5 held local address
        '{32'h841, 32'h100, 32'hD0, 32'd8,  1'b1, 1'b0},  // R5 held, local->host
        '{32'h043, 32'h140, 32'hE0, 32'd7,  1'b1, 1'b1},  // R4 remainder dropped
        '{32'h040, 32'h180, 32'hF0, 32'd0,  1'b0, 1'b0}   // R7 zero count direct
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        h_req, h_we, h_rdy = 1'b1, l_req, l_we, l_rdy = 1'b1;
    logic [31:0] h_addr, h_wdata, h_rdata, l_addr, l_wdata, l_rdata;

    logic [31:0] hmem [256];
    logic [31:0] lmem [256];
    logic [31:0] exp_h [256];
    logic [31:0] exp_l [256];
    logic        hstall = 1'b0, lhold_low = 1'b0, lwait = 1'b1;
    logic [7:0]  lfsr = 8'h5A;
    int          checks = 0, fails = 0, cyc = 0, hreq_cnt = 0;
    logic [31:0] rd;

    always #(CLK_P/2) clk = ~clk;

    dmac_sg_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rdy(h_rdy),
        .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rdy(l_rdy)
    );

    assign h_rdata = hmem[h_addr[9:2]];
    assign l_rdata = lmem[l_addr[7:0]];

    always @(posedge clk) begin
        lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        h_rdy <= hstall ? lfsr[0] : 1'b1;
        l_rdy <= lhold_low ? 1'b0 : (hstall ? lfsr[2] : 1'b1);
        if (h_req) hreq_cnt <= hreq_cnt + 1;
        if (h_req && h_we && h_rdy) hmem[h_addr[9:2]] <= h_wdata;
        if (l_req && l_we && (l_rdy || !lwait)) lmem[l_addr[7:0]] <= l_wdata;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic init_mems();
        for (int i = 0; i < 256; i++) begin
            hmem[i]  = {8'hA5, 8'(i), ~8'(i), 8'(i) + 8'h3C};
            lmem[i]  = 32'h5A00_0000 | (32'(i) * 32'h0001_0101);
            exp_h[i] = hmem[i];
            exp_l[i] = lmem[i];
        end
    endtask

    task automatic put_word(input logic [31:0] byte_addr, input logic [31:0] v);
        hmem[byte_addr[9:2]]  = v;
        exp_h[byte_addr[9:2]] = v;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] ha, input logic [31:0] la,
                            input logic [31:0] c, input logic [31:0] n);
        put_word(a, ha); put_word(a + 4, la); put_word(a + 8, c); put_word(a + 12, n);
    endtask

    // reference transfer taken from R3 R4 R5
    task automatic apply_ref(input logic [31:0] mode, input logic [31:0] ha, input logic [31:0] la,
                             input logic [31:0] c, input logic dir);
        int wbytes;
        logic [31:0] m;
        int nb;
        wbytes = (mode[1:0] == 2'b00) ? 1 : (mode[1:0] == 2'b01) ? 2 : 4;
        m = (wbytes == 1) ? 32'hFF : (wbytes == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
        nb = int'(c) / wbytes;
        for (int i = 0; i < nb; i++) begin
            int hi, li;
            hi = (int'(ha) >> 2) + i;
            li = (int'(la) + (mode[11] ? 0 : i * wbytes)) & 255;
            if (dir) exp_h[hi] = exp_l[li] & m;
            else     exp_l[li] = exp_h[hi] & m;
        end
    endtask

    task automatic cmp_mems(input string req);
        int bad;
        logic [31:0] a, e;
        bad = 0; a = '0; e = '0;
        for (int i = 0; i < 256; i++) begin
            if (bad == 0 && hmem[i] !== exp_h[i]) begin bad = 1; a = hmem[i]; e = exp_h[i]; end
            if (bad == 0 && lmem[i] !== exp_l[i]) begin bad = 2; a = lmem[i]; e = exp_l[i]; end
        end
        chk(bad == 0, req, a, e);
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 3000; i++) begin
            rreg(3'd5, s);
            if (s[4]) break;
        end
        chk(s == 32'h10, req, s, 32'h10);
    endtask

    initial begin
        init_mems();
        repeat (3) @(negedge clk);
        // reset state, R1
        for (int a = 0; a < 6; a++) begin
            rreg(3'(a), rd);
            chk(rd == 0, "R1 reset register value", rd, 0);
        end
        chk(!h_req && !l_req, "R1 no request in reset", {h_req, l_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 readback
        for (int a = 0; a < 5; a++) begin
            wreg(3'(a), 32'h1234_0000 + 32'(a) * 32'h111);
            rreg(3'(a), rd);
            chk(rd == 32'h1234_0000 + 32'(a) * 32'h111, "R1 readback", rd, 32'h1234_0000 + 32'(a) * 32'h111);
        end
        wreg(3'd0, 32'h0);
        rreg(3'd5, rd);
        chk(rd == 0, "R1 status idle", rd, 0);

        // R2 partial command does not start
        wreg(3'd0, 32'h043); wreg(3'd1, 32'h0); wreg(3'd2, 32'h0);
        wreg(3'd3, 32'd16);  wreg(3'd4, 32'h1);
        wreg(3'd5, 32'h2);
        wreg(3'd5, 32'h1);
        repeat (30) @(negedge clk);
        rreg(3'd5, rd);
        chk(rd == 0, "R2 partial go leaves done clear", rd, 0);
        chk(hreq_cnt == 0, "R2 partial go raises no request", hreq_cnt, 0);
        cmp_mems("R2 memories untouched");

        // table walk: R3 R4 R5 R7 R8 R11
        for (int v = 0; v < NV; v++) begin
            init_mems();
            hstall = VT[v].stall;
            lwait  = VT[v].mode[6];
            wreg(3'd0, VT[v].mode);
            wreg(3'd1, VT[v].ha);
            wreg(3'd2, VT[v].la);
            wreg(3'd3, VT[v].cnt);
            wreg(3'd4, {28'h0, VT[v].dir, 3'b001});
            wreg(3'd5, 32'h3);
            rreg(3'd5, rd);
            chk(rd == 0, "R8 done cleared by go", rd, 0);
            wait_done("R8 done after direct job");
            apply_ref(VT[v].mode, VT[v].ha, VT[v].la, VT[v].cnt, VT[v].dir);
            cmp_mems("R3 R4 R5 direct transfer data");
        end

        // R6 R7 chain with a skipped middle descriptor, host stalls on
        init_mems();
        hstall = 1'b1; lwait = 1'b1;
        put_desc(32'h300, 32'h040, 32'h10, 32'd16, 32'h311);
        put_desc(32'h310, 32'h000, 32'h00, 32'd0,  32'h321);
        put_desc(32'h320, 32'h080, 32'h20, 32'd12, 32'h00B);
        wreg(3'd0, 32'h243);
        wreg(3'd4, 32'h305);
        wreg(3'd5, 32'h3);
        wait_done("R6 done after chain");
        apply_ref(32'h243, 32'h040, 32'h10, 32'd16, 1'b0);
        apply_ref(32'h243, 32'h080, 32'h20, 32'd12, 1'b1);
        cmp_mems("R6 R7 chain data");

        // R7 chain ending on a zero-count last descriptor, 16-bit
        init_mems();
        hstall = 1'b0;
        put_desc(32'h340, 32'h1C0, 32'h70, 32'd8, 32'h351);
        put_desc(32'h350, 32'h000, 32'h00, 32'd0, 32'h003);
        wreg(3'd0, 32'h241);
        wreg(3'd4, 32'h340);
        wreg(3'd5, 32'h3);
        wait_done("R7 done with zero-count tail");
        apply_ref(32'h241, 32'h1C0, 32'h70, 32'd8, 1'b0);
        cmp_mems("R7 zero-count tail moves nothing");

        // R9 R10 go while stalled on local ready is ignored
        init_mems();
        lhold_low = 1'b1; lwait = 1'b1;
        wreg(3'd0, 32'h043); wreg(3'd1, 32'h000); wreg(3'd2, 32'h10);
        wreg(3'd3, 32'd16);  wreg(3'd4, 32'h1);
        wreg(3'd5, 32'h3);
        repeat (30) @(negedge clk);
        rreg(3'd5, rd);
        chk(rd == 0, "R10 stalled on local ready", rd, 0);
        wreg(3'd2, 32'h60); wreg(3'd3, 32'd32);
        wreg(3'd5, 32'h3);
        lhold_low = 1'b0;
        wait_done("R9 done after ignored go");
        apply_ref(32'h043, 32'h000, 32'h10, 32'd16, 1'b0);
        repeat (40) @(negedge clk);
        cmp_mems("R9 only first job ran");
        rreg(3'd5, rd);
        chk(rd == 32'h10, "R9 no restart after done", rd, 32'h10);

        // R10 waiting disabled: local ready ignored
        init_mems();
        lhold_low = 1'b1; lwait = 1'b0;
        wreg(3'd0, 32'h003); wreg(3'd1, 32'h020); wreg(3'd2, 32'h30);
        wreg(3'd3, 32'd12);  wreg(3'd4, 32'h1);
        wreg(3'd5, 32'h3);
        wait_done("R10 completes without local ready");
        apply_ref(32'h003, 32'h020, 32'h30, 32'd12, 1'b0);
        cmp_mems("R10 no-wait data");
        lhold_low = 1'b0;

        summary();
    end
endmodule